// File: doc/BRIEF.md
# Wide Word Slice Serializer

The block takes one wide data word and plays it out as a run of narrow slices, one per clock. The lowest slice goes first. A word is accepted only while the block is idle and the word strobe is high. The stored copy is then streamed slice by slice. After the last slice the block waits until a downstream consumer reports that all of its lanes have finished, and only then signals completion and returns to idle.

The word is not cut up by a counter-indexed multiplexer. It sits in a register that moves right by one slice width every streaming cycle, and the output is always read from its low bits. This keeps the select logic in front of the output register to a single two-way choice per bit. A small saturating index only marks the final slice.

Top module: `wss_serializer`

## Requirements
- R1: Synchronous active-high reset, while held and on the cycle after, forces slice_out to 0 and slice_valid, slice_last and done to 0. Reset abandons any word in flight and leaves the block idle, ready to accept a new word.
- R2: While idle, a word is captured only at a clock edge where word_valid is high. slice_valid stays 0 in every idle cycle and in the cycle right after the capture edge.
- R3: Slice k (k = 0..31) equals bits [32k+31:32k] of the captured word. Slice k is on slice_out in the cycle after the (k+2)-th clock edge, counting the capture edge as the first.
- R4: slice_valid is high for exactly 32 consecutive cycles per captured word.
- R5: slice_last is high only together with slice 31, and slice_valid is low in the following cycle.
- R6: Whenever slice_valid is 0, slice_out is 0.
- R7: After slice 31 the block waits. done rises in the cycle after the first edge at which all 32 bits of lane_done are 1 while waiting, and stays high for exactly one cycle. Values of lane_done seen during streaming, including all ones, neither shorten the stream nor raise done.
- R8: word_valid and word_in are ignored while streaming or waiting. The slices of the current word come out unchanged, and no new stream begins before done.
- R9: In the cycle where done is high the block is idle. A word presented in that cycle is captured at the next edge, and its slice 0 follows one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| word_in | input | 1024 | Word to be serialized |
| word_valid | input | 1 | Word strobe, acted on only when idle |
| lane_done | input | 32 | Completion flags from the downstream lanes |
| slice_out | output | 32 | Registered slice |
| slice_valid | output | 1 | Slice qualifier |
| slice_last | output | 1 | Marks slice 31 |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench changes inputs on falling edges and reads outputs on the next falling edge, so each reading follows a known number of rising edges. Counting from the edge that captures a word, the output is still empty one cycle later. Slice k is then read k+1 cycles later, and done is read one cycle after the first all-ones completion vector given during the wait. In every cycle of a stream and a wait, the bench drives junk words, junk strobes and random completion vectors that sometimes are all ones, so that each ignored input is paired with a read of the outputs it could have disturbed.

// File: rtl/wss_pkg.sv
`timescale 1ns/1ps
package wss_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STREAM = 2'd1,
        ST_WAIT   = 2'd2
    } wss_state_e;

    typedef struct packed {
        wss_state_e state;
        logic       done;
    } wss_ctrl_t;

endpackage

// File: rtl/wss_slice_shifter.sv
`timescale 1ns/1ps
module wss_slice_shifter #(
    parameter int WORD_W  = 1024,
    parameter int SLICE_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic               shift,
    input  logic [WORD_W-1:0]  din,
    output logic [SLICE_W-1:0] head
);

    logic [WORD_W-1:0] store_d, store_q;

    always_comb begin
        store_d = store_q;
        if (load) begin
            store_d = din;
        end else if (shift) begin
            store_d = store_q >> SLICE_W;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            store_q <= '0;
        end else begin
            store_q <= store_d;
        end
    end

    assign head = store_q[SLICE_W-1:0];

    // R3: after a capture, the head holds the lowest slice of the word
    a_r3_load_head: assert property (@(posedge clk) disable iff (rst)
        load |=> head == $past(din[SLICE_W-1:0]));

endmodule

// File: rtl/wss_slice_index.sv
`timescale 1ns/1ps
module wss_slice_index #(
    parameter int NUM_SLICES = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic step,
    output logic at_last
);

    localparam int CNT_W = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NUM_SLICES - 1);

    logic [CNT_W-1:0] idx_d, idx_q;

    always_comb begin
        idx_d = idx_q;
        if (clear) begin
            idx_d = '0;
        end else if (step && (idx_q != LAST_IDX)) begin
            idx_d = idx_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else begin
            idx_q <= idx_d;
        end
    end

    assign at_last = (idx_q == LAST_IDX);

    // R4: the index saturates at the final slice instead of wrapping
    a_r4_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (at_last && !clear) |=> at_last);

endmodule

// File: rtl/wss_ctrl.sv
`timescale 1ns/1ps
module wss_ctrl
    import wss_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic word_valid,
    input  logic all_done,
    input  logic at_last,
    output logic load,
    output logic streaming,
    output logic done
);

    wss_ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d      = ctrl_q;
        ctrl_d.done = 1'b0;
        load        = 1'b0;
        streaming   = 1'b0;
        case (ctrl_q.state)
            ST_IDLE: begin
                if (word_valid) begin
                    load         = 1'b1;
                    ctrl_d.state = ST_STREAM;
                end
            end
            ST_STREAM: begin
                streaming = 1'b1;
                if (at_last) begin
                    ctrl_d.state = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (all_done) begin
                    ctrl_d.state = ST_IDLE;
                    ctrl_d.done  = 1'b1;
                end
            end
            default: begin
                ctrl_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '{state: ST_IDLE, done: 1'b0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign done = ctrl_q.done;

    // R7: done lasts a single cycle
    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: the done cycle is an idle cycle
    a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> ctrl_q.state == ST_IDLE);

    // R7: waiting persists until the completion vector is full
    a_r7_wait_hold: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.state == ST_WAIT && !all_done) |=> (ctrl_q.state == ST_WAIT && !done));

    // R8: streaming runs on regardless of new words or completion flags
    a_r8_stream_runs: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.state == ST_STREAM && !at_last) |=> ctrl_q.state == ST_STREAM);

endmodule

// File: rtl/wss_serializer.sv
`timescale 1ns/1ps
module wss_serializer #(
    parameter int WORD_W  = 1024,
    parameter int SLICE_W = 32,
    parameter int LANE_W  = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [WORD_W-1:0]  word_in,
    input  logic               word_valid,
    input  logic [LANE_W-1:0]  lane_done,
    output logic [SLICE_W-1:0] slice_out,
    output logic               slice_valid,
    output logic               slice_last,
    output logic               done
);

    localparam int NUM_SLICES = WORD_W / SLICE_W;

    typedef struct packed {
        logic [SLICE_W-1:0] slice;
        logic               valid;
        logic               last;
    } wss_out_t;

    logic               load, streaming, at_last, all_done;
    logic [SLICE_W-1:0] head;
    wss_out_t           out_d, out_q;

    assign all_done = &lane_done;

    wss_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .word_valid (word_valid),
        .all_done   (all_done),
        .at_last    (at_last),
        .load       (load),
        .streaming  (streaming),
        .done       (done)
    );

    wss_slice_shifter #(
        .WORD_W  (WORD_W),
        .SLICE_W (SLICE_W)
    ) u_shift (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .shift (streaming),
        .din   (word_in),
        .head  (head)
    );

    wss_slice_index #(
        .NUM_SLICES (NUM_SLICES)
    ) u_index (
        .clk     (clk),
        .rst     (rst),
        .clear   (load),
        .step    (streaming),
        .at_last (at_last)
    );

    always_comb begin
        out_d = '0;
        if (streaming) begin
            out_d.slice = head;
            out_d.valid = 1'b1;
            out_d.last  = at_last;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign slice_out   = out_q.slice;
    assign slice_valid = out_q.valid;
    assign slice_last  = out_q.last;

    // R5: the last flag only marks a valid slice
    a_r5_last_valid: assert property (@(posedge clk) disable iff (rst)
        slice_last |-> slice_valid);

    // R5: the stream ends right after the last slice
    a_r5_last_ends: assert property (@(posedge clk) disable iff (rst)
        slice_last |=> !slice_valid);

    // R6: no data leaks out when nothing is valid
    a_r6_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !slice_valid |-> slice_out == '0);

    // R7: completion is never signalled in the middle of a stream
    a_r7_no_done_mid: assert property (@(posedge clk) disable iff (rst)
        (slice_valid && !slice_last) |=> !done);

endmodule

// File: tb/sim_wss_serializer.sv
`timescale 1ns/1ps
module sim_wss_serializer;

    localparam int WORD_W  = 1024;
    localparam int SLICE_W = 32;
    localparam int LANE_W  = 32;
    localparam int NSL     = WORD_W / SLICE_W;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [WORD_W-1:0]  word_in = '0;
    logic               word_valid = 1'b0;
    logic [LANE_W-1:0]  lane_done = '0;
    logic [SLICE_W-1:0] slice_out;
    logic               slice_valid, slice_last, done;

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 1'b0;

    always #2.5 clk = ~clk;

    wss_serializer u0 (
        .clk         (clk),
        .rst         (rst),
        .word_in     (word_in),
        .word_valid  (word_valid),
        .lane_done   (lane_done),
        .slice_out   (slice_out),
        .slice_valid (slice_valid),
        .slice_last  (slice_last),
        .done        (done)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [WORD_W-1:0] rand_word();
        logic [WORD_W-1:0] w;
        for (int i = 0; i < WORD_W / 32; i++) w[i*32 +: 32] = $urandom;
        return w;
    endfunction

    function automatic logic [LANE_W-1:0] partial_lanes();
        logic [LANE_W-1:0] r;
        r = LANE_W'($urandom);
        if (&r) r[$urandom % LANE_W] = 1'b0;
        return r;
    endfunction

    task automatic quiet_check(input string tag);
        chk(slice_valid == 1'b0, {tag, " valid"}, 32'(slice_valid), 32'd0);
        chk(slice_out == '0, {tag, " slice"}, slice_out, 32'd0);
        chk(slice_last == 1'b0, {tag, " last"}, 32'(slice_last), 32'd0);
    endtask

    // called at a falling edge with the block idle; returns at the falling edge where done is high
    task automatic send(input logic [WORD_W-1:0] w, input int nwait);
        word_in    = w;
        word_valid = 1'b1;
        @(negedge clk);
        chk(slice_valid == 1'b0, "R2 no slice before first", 32'(slice_valid), 32'd0);
        chk(done == 1'b0, "R7 done one cycle wide", 32'(done), 32'd0);
        word_valid = 1'($urandom);
        word_in    = rand_word();
        lane_done  = LANE_W'($urandom);
        for (int k = 0; k < NSL; k++) begin
            @(negedge clk);
            chk(slice_out == w[k*SLICE_W +: SLICE_W], "R3 slice order", slice_out, w[k*SLICE_W +: SLICE_W]);
            chk(slice_valid == 1'b1, "R4 valid during stream", 32'(slice_valid), 32'd1);
            chk(slice_last == (k == NSL - 1), "R5 last flag", 32'(slice_last), 32'(k == NSL - 1));
            chk(done == 1'b0, "R7 no done while streaming", 32'(done), 32'd0);
            word_valid = 1'($urandom);     // R8 junk strobe
            word_in    = rand_word();      // R8 junk word
            if (k == NSL - 1)
                lane_done = (nwait == 0) ? '1 : partial_lanes();
            else
                lane_done = ($urandom % 4 == 0) ? '1 : LANE_W'($urandom);
        end
        for (int i = 0; i < nwait; i++) begin
            @(negedge clk);
            quiet_check("R6 waiting");
            chk(done == 1'b0, "R7 waits for full vector", 32'(done), 32'd0);
            lane_done  = (i == nwait - 1) ? '1 : partial_lanes();
            word_valid = 1'($urandom);     // R8 ignored while waiting
            word_in    = rand_word();
        end
        @(negedge clk);
        chk(done == 1'b1, "R7 done after completion", 32'(done), 32'd1);
        chk(slice_valid == 1'b0, "R6 no valid at done", 32'(slice_valid), 32'd0);
        word_valid = 1'b0;
        lane_done  = partial_lanes();
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        logic [WORD_W-1:0] w;
        void'($urandom(32'h5EED_1234));

        // R1: reset state
        repeat (3) @(negedge clk);
        quiet_check("R1 reset");
        chk(done == 1'b0, "R1 reset done", 32'(done), 32'd0);
        rst = 1'b0;

        // R2: idle with strobe low captures nothing
        for (int i = 0; i < 6; i++) begin
            word_in = rand_word();
            @(negedge clk);
            quiet_check("R2 idle no capture");
        end

        // directed: slice k carries value k plus a marker
        for (int k = 0; k < NSL; k++) w[k*SLICE_W +: SLICE_W] = 32'hA500_0000 | 32'(k);
        send(w, 0);
        @(negedge clk);
        chk(done == 1'b0, "R7 done single cycle", 32'(done), 32'd0);
        quiet_check("R6 idle after done");

        send('1, 3);
        @(negedge clk);
        chk(done == 1'b0, "R7 done single cycle", 32'(done), 32'd0);

        // R9: back-to-back words, the next presented in the done cycle
        send(rand_word(), 1);
        send(rand_word(), 0);
        send(rand_word(), 2);
        @(negedge clk);

        // R1: reset in the middle of a stream
        word_in = rand_word();
        word_valid = 1'b1;
        @(negedge clk);
        word_valid = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        quiet_check("R1 reset mid-stream");
        chk(done == 1'b0, "R1 reset mid-stream done", 32'(done), 32'd0);
        rst = 1'b0;
        lane_done = '1;
        @(negedge clk);
        quiet_check("R1 stream abandoned");
        chk(done == 1'b0, "R1 no done after reset", 32'(done), 32'd0);
        lane_done = partial_lanes();
        send(rand_word(), 1);

        // random words, waits and gaps
        for (int n = 0; n < 24; n++) begin
            send(rand_word(), $urandom % 7);
            if ($urandom % 2) begin
                @(negedge clk);
                chk(done == 1'b0, "R7 done single cycle", 32'(done), 32'd0);
                quiet_check("R6 idle gap");
            end
        end
        @(negedge clk);
        finish_run();
    end

    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        finish_run();
    end

endmodule